// File: doc/BRIEF.md
# TDM Frame Channel Deserializer

This block is the receive half of a time-division multiplexed serial port that has a single data line, a bit clock and a frame sync. All three serial lines are sampled in the system clock domain. A configuration bit picks the bit-clock edge that is active. On each active edge the block reads the sync and data lines. A new frame starts when the sync line is seen at its active level after it was seen inactive. After a programmable delay of 0 to 3 bit clocks, the following bits are cut into `cfg_nchan` channels. Every channel has the same word size of 2, 4, 8 or 16 bits.

Each completed channel word appears for one cycle with its channel index, but only if that channel's bit in the active mask is set. A disabled channel still uses its slots in the frame. When the last channel is done, the block ignores the data line until the next frame sync. A shared write offset moves forward by one at the end of every complete frame and wraps at a programmable buffer length. Two threshold comparators on this offset raise interrupt pulses, so software can work on one half of a buffer while the other half fills.

Top module: `tdm_rx_deser`

## Requirements
- R1: After reset, `word_valid`, `sync_err`, `irq_a`, `irq_b` and `wr_offset` are all zero.
- R2: `cfg_wsize` sets the channel word size: 0 gives 2 bits, 1 gives 4, 2 gives 8 and 3 gives 16. Each channel takes that many consecutive data bits. `word_data` holds the word in its low bits with zeros above it, and `word_chan` gives the channel number counted from 0 at the start of the frame.
- R3: With `cfg_edge_fall`=0 the data and sync lines are sampled on rising bit-clock edges. With 1 they are sampled on falling edges. Edges of the other direction have no effect.
- R4: With `cfg_sync_low`=0 the sync line is active high; with 1 it is active low. A frame starts at the first active edge where sync is active after an active edge where it was inactive.
- R5: With `cfg_delay`=D, the data bit sampled D active edges after the frame-start edge is the first bit of channel 0. D=0 means the frame-start edge itself carries that bit.
- R6: With `cfg_lsb_first`=0 the first bit received for a channel is the word's MSB. With 1 it is the LSB.
- R7: A channel whose bit in `cfg_active` is 0 still takes up its slots in the frame but never raises `word_valid`.
- R8: A frame holds `cfg_nchan` channels, with 1 ≤ `cfg_nchan` ≤ MAX_CHAN. Data bits after the last channel and before the next frame start produce no words.
- R9: A frame start detected before the current frame has finished raises `sync_err` for one cycle. The partial frame is dropped, bit counting starts again from the new start, and the offset does not move.
- R10: `wr_offset` goes up by one after each complete frame. It becomes 0 instead of reaching `cfg_buf_len`.
- R11: `irq_a` (and `irq_b`) pulses for one cycle when `wr_offset` takes a new value equal to `cfg_thr_a` (and `cfg_thr_b`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_sync | input | 1 | Serial frame sync |
| ser_data | input | 1 | Serial receive data |
| cfg_edge_fall | input | 1 | 1: sample on falling bit-clock edge |
| cfg_sync_low | input | 1 | 1: frame sync active low |
| cfg_delay | input | 2 | Bit clocks from frame start to first data bit |
| cfg_lsb_first | input | 1 | 1: first bit of a word is its LSB |
| cfg_wsize | input | 2 | Word size code (2 << code bits) |
| cfg_nchan | input | CH_W+1 | Channels per frame |
| cfg_active | input | MAX_CHAN | Per-channel enable mask |
| cfg_buf_len | input | OFF_W | Offset wrap length |
| cfg_thr_a | input | OFF_W | First offset threshold |
| cfg_thr_b | input | OFF_W | Second offset threshold |
| word_valid | output | 1 | Word strobe |
| word_data | output | WORD_MAX | Assembled word, zero-extended |
| word_chan | output | CH_W | Channel index of the word |
| sync_err | output | 1 | Early frame-start pulse |
| wr_offset | output | OFF_W | Shared write offset |
| irq_a | output | 1 | First threshold interrupt pulse |
| irq_b | output | 1 | Second threshold interrupt pulse |

## Verification
A bit-clock transition passes through the SYNC_STAGES input registers and is then turned into an edge event. `word_valid` and `sync_err` therefore change on the third rising system clock after the transition with the default two stages. `wr_offset`, `irq_a` and `irq_b` change one cycle after the frame's final word slot. The bench holds each bit-clock level for four system clocks, so every result has settled before the next serial edge. It captures strobes on falling system-clock edges and compares whole word sequences, pulse counts and the offset only after an idle gap that follows each frame.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_DATA  = 2'd2
   } rx_state_e;

   // word size in bits from the 2-bit size code
   function automatic logic [4:0] word_bits(input logic [1:0] code);
      return 5'd2 << code;
   endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_sync,
   input  logic ser_data,
   input  logic cfg_edge_fall,
   input  logic cfg_sync_low,
   output logic bit_ev,
   output logic bit_val,
   output logic sync_hit
);

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] clk_p, sync_p, data_p;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_p  <= '0;
               sync_p <= '0;
               data_p <= '0;
            end else begin
               clk_p  <= ser_clk;
               sync_p <= ser_sync;
               data_p <= ser_data;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_p  <= '0;
               sync_p <= '0;
               data_p <= '0;
            end else begin
               clk_p  <= {clk_p[SYNC_STAGES-2:0], ser_clk};
               sync_p <= {sync_p[SYNC_STAGES-2:0], ser_sync};
               data_p <= {data_p[SYNC_STAGES-2:0], ser_data};
            end
         end
      end
   endgenerate

   logic clk_q, clk_prev, sync_lvl, sync_was;
   assign clk_q    = clk_p[SYNC_STAGES-1];
   assign sync_lvl = sync_p[SYNC_STAGES-1] ^ cfg_sync_low;
   assign bit_val  = data_p[SYNC_STAGES-1];
   assign bit_ev   = cfg_edge_fall ? (clk_prev & ~clk_q) : (clk_q & ~clk_prev);
   assign sync_hit = bit_ev & sync_lvl & ~sync_was;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         sync_was <= 1'b1;
      end else begin
         clk_prev <= clk_q;
         if (bit_ev) sync_was <= sync_lvl;
      end
   end

endmodule

// File: rtl/tdm_word_asm.sv
module tdm_word_asm
   import tdm_rx_pkg::*;
#(
   parameter  int MAX_CHAN = 256,
   parameter  int WORD_MAX = 16,
   localparam int CH_W     = $clog2(MAX_CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_ev,
   input  logic                bit_val,
   input  logic                sync_hit,
   input  logic [1:0]          cfg_delay,
   input  logic [1:0]          cfg_wsize,
   input  logic                cfg_lsb_first,
   input  logic [CH_W:0]       cfg_nchan,
   input  logic [MAX_CHAN-1:0] cfg_active,
   output logic                word_valid,
   output logic [WORD_MAX-1:0] word_data,
   output logic [CH_W-1:0]     word_chan,
   output logic                sync_err,
   output logic                frame_done
);

   localparam int BI_W = $clog2(WORD_MAX) + 1;

   initial begin
      assert (WORD_MAX >= 16) else $error("WORD_MAX must hold a 16-bit word");
      assert (MAX_CHAN >= 2 && (1 << CH_W) == MAX_CHAN) else $error("MAX_CHAN must be a power of two");
   end

   rx_state_e           state;
   logic [1:0]          dly_cnt;
   logic [BI_W-1:0]     bit_idx;
   logic [CH_W-1:0]     chan;
   logic [WORD_MAX-1:0] shreg;

   logic [BI_W-1:0]     wbits, cur_bit;
   logic [CH_W-1:0]     cur_chan;
   logic                absorb, first, last_bit, last_chan;
   logic [WORD_MAX-1:0] sh_lsb, sh_next, wmask;

   assign wbits = BI_W'(word_bits(cfg_wsize));
   assign wmask = ~({WORD_MAX{1'b1}} << wbits);

   always_comb begin
      absorb = 1'b0;
      if (bit_ev) begin
         if (sync_hit)                absorb = (cfg_delay == 2'd0);
         else if (state == ST_DELAY)  absorb = (dly_cnt == 2'd0);
         else                         absorb = (state == ST_DATA);
      end
      first     = sync_hit || (state == ST_DELAY);
      cur_bit   = first ? '0 : bit_idx;
      cur_chan  = first ? '0 : chan;
      last_bit  = (cur_bit == wbits - 1'b1);
      last_chan = ({1'b0, cur_chan} == cfg_nchan - 1'b1);
      sh_lsb    = shreg;
      sh_lsb[cur_bit[BI_W-2:0]] = bit_val;
      sh_next   = cfg_lsb_first ? sh_lsb : {shreg[WORD_MAX-2:0], bit_val};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         dly_cnt    <= '0;
         bit_idx    <= '0;
         chan       <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_chan  <= '0;
         sync_err   <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         word_valid <= absorb && last_bit && cfg_active[cur_chan];
         frame_done <= absorb && last_bit && last_chan;
         sync_err   <= sync_hit && (state != ST_IDLE);
         if (absorb && last_bit) begin
            word_data <= sh_next & wmask;
            word_chan <= cur_chan;
         end
         if (sync_hit) begin
            state   <= (cfg_delay == 2'd0) ? ST_DATA : ST_DELAY;
            dly_cnt <= cfg_delay - 2'd1;
         end else if (bit_ev && state == ST_DELAY && dly_cnt != 2'd0) begin
            dly_cnt <= dly_cnt - 2'd1;
         end
         if (absorb) begin
            shreg <= sh_next;
            if (last_bit) begin
               bit_idx <= '0;
               if (last_chan) begin
                  state <= ST_IDLE;
                  chan  <= '0;
               end else begin
                  state <= ST_DATA;
                  chan  <= cur_chan + 1'b1;
               end
            end else begin
               state   <= ST_DATA;
               bit_idx <= cur_bit + 1'b1;
               chan    <= cur_chan;
            end
         end
      end
   end

   // R7: a strobed word always belongs to an enabled channel
   a_r7_active_only: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> cfg_active[word_chan]);

   // R8: channel index stays inside the programmed frame
   a_r8_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ({1'b0, word_chan} < cfg_nchan));

   // R2: no bits above the word size
   a_r2_word_masked: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ((word_data >> wbits) == '0));

   // R9: an early frame start never coincides with a word
   a_r9_no_word_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> !word_valid && !frame_done);

endmodule

// File: rtl/tdm_offset_ctl.sv
module tdm_offset_ctl #(
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic [OFF_W-1:0] cfg_buf_len,
   input  logic [OFF_W-1:0] cfg_thr_a,
   input  logic [OFF_W-1:0] cfg_thr_b,
   output logic [OFF_W-1:0] wr_offset,
   output logic             irq_a,
   output logic             irq_b
);

   initial begin
      assert (OFF_W >= 1) else $error("OFF_W must be positive");
   end

   logic [OFF_W-1:0] inc, nxt;
   assign inc = wr_offset + 1'b1;
   assign nxt = (inc == cfg_buf_len) ? '0 : inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_offset <= '0;
         irq_a     <= 1'b0;
         irq_b     <= 1'b0;
      end else begin
         irq_a <= frame_done && (nxt == cfg_thr_a);
         irq_b <= frame_done && (nxt == cfg_thr_b);
         if (frame_done) wr_offset <= nxt;
      end
   end

   // R10: the offset only steps by one or wraps to zero
   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_offset) |-> (wr_offset == '0) || (wr_offset == $past(wr_offset) + 1'b1));

   // R11: interrupt pulses only when the offset sits on its threshold
   a_r11_irq_a_match: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> (wr_offset == cfg_thr_a));

   a_r11_irq_b_match: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> (wr_offset == cfg_thr_b));

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
   parameter  int MAX_CHAN    = 256,
   parameter  int WORD_MAX    = 16,
   parameter  int OFF_W       = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int CH_W        = $clog2(MAX_CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_sync,
   input  logic                ser_data,
   input  logic                cfg_edge_fall,
   input  logic                cfg_sync_low,
   input  logic [1:0]          cfg_delay,
   input  logic                cfg_lsb_first,
   input  logic [1:0]          cfg_wsize,
   input  logic [CH_W:0]       cfg_nchan,
   input  logic [MAX_CHAN-1:0] cfg_active,
   input  logic [OFF_W-1:0]    cfg_buf_len,
   input  logic [OFF_W-1:0]    cfg_thr_a,
   input  logic [OFF_W-1:0]    cfg_thr_b,
   output logic                word_valid,
   output logic [WORD_MAX-1:0] word_data,
   output logic [CH_W-1:0]     word_chan,
   output logic                sync_err,
   output logic [OFF_W-1:0]    wr_offset,
   output logic                irq_a,
   output logic                irq_b
);

   logic bit_ev, bit_val, sync_hit, frame_done;

   tdm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
      .cfg_edge_fall(cfg_edge_fall), .cfg_sync_low(cfg_sync_low),
      .bit_ev(bit_ev), .bit_val(bit_val), .sync_hit(sync_hit)
   );

   tdm_word_asm #(.MAX_CHAN(MAX_CHAN), .WORD_MAX(WORD_MAX)) u_asm (
      .clk(clk), .rst_n(rst_n),
      .bit_ev(bit_ev), .bit_val(bit_val), .sync_hit(sync_hit),
      .cfg_delay(cfg_delay), .cfg_wsize(cfg_wsize), .cfg_lsb_first(cfg_lsb_first),
      .cfg_nchan(cfg_nchan), .cfg_active(cfg_active),
      .word_valid(word_valid), .word_data(word_data), .word_chan(word_chan),
      .sync_err(sync_err), .frame_done(frame_done)
   );

   tdm_offset_ctl #(.OFF_W(OFF_W)) u_off (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
      .cfg_buf_len(cfg_buf_len), .cfg_thr_a(cfg_thr_a), .cfg_thr_b(cfg_thr_b),
      .wr_offset(wr_offset), .irq_a(irq_a), .irq_b(irq_b)
   );

endmodule

// File: tb/tdm_rx_deser_tb.sv
`timescale 1ns/1ps
module tdm_rx_deser_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         ser_clk = 1'b0, ser_sync = 1'b0, ser_data = 1'b0;
   logic         cfg_edge_fall = 1'b0, cfg_sync_low = 1'b0, cfg_lsb_first = 1'b0;
   logic [1:0]   cfg_delay = 2'd0, cfg_wsize = 2'd0;
   logic [8:0]   cfg_nchan = 9'd3;
   logic [255:0] cfg_active = '0;
   logic [7:0]   cfg_buf_len = 8'd0, cfg_thr_a = 8'd200, cfg_thr_b = 8'd201;
   logic         word_valid, sync_err, irq_a, irq_b;
   logic [15:0]  word_data;
   logic [7:0]   word_chan, wr_offset;

   tdm_rx_deser u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
      .cfg_edge_fall(cfg_edge_fall), .cfg_sync_low(cfg_sync_low), .cfg_delay(cfg_delay),
      .cfg_lsb_first(cfg_lsb_first), .cfg_wsize(cfg_wsize), .cfg_nchan(cfg_nchan),
      .cfg_active(cfg_active), .cfg_buf_len(cfg_buf_len), .cfg_thr_a(cfg_thr_a),
      .cfg_thr_b(cfg_thr_b), .word_valid(word_valid), .word_data(word_data),
      .word_chan(word_chan), .sync_err(sync_err), .wr_offset(wr_offset),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   int n_tests = 0, n_fail = 0;
   int exp_ch [0:511];
   int exp_dt [0:511];
   int act_ch [0:511];
   int act_dt [0:511];
   int n_exp = 0, n_act = 0, cnt_err = 0, cnt_ia = 0, cnt_ib = 0;
   int bits [0:4095];

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid) begin
            if (n_act < 512) begin
               act_ch[n_act] = int'(word_chan);
               act_dt[n_act] = int'(word_data);
            end
            n_act = n_act + 1;
         end
         if (sync_err) cnt_err = cnt_err + 1;
         if (irq_a)    cnt_ia  = cnt_ia + 1;
         if (irq_b)    cnt_ib  = cnt_ib + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int word_val(input int f, input int ch, input int w);
      return ((f * 37 + ch * 11 + 5 + f * ch * 3) & ((1 << w) - 1));
   endfunction

   task automatic do_reset();
      rst_n    = 1'b0;
      ser_clk  = cfg_edge_fall;
      ser_sync = cfg_sync_low;
      ser_data = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      n_act = 0; n_exp = 0; cnt_err = 0; cnt_ia = 0; cnt_ib = 0;
   endtask

   // one bit period: set lines, active edge, back to idle level
   task automatic bit_period(input bit s, input bit d);
      ser_sync = s ^ cfg_sync_low;
      ser_data = d;
      repeat (4) @(negedge clk);
      ser_clk = ~cfg_edge_fall;
      repeat (4) @(negedge clk);
      ser_clk = cfg_edge_fall;
   endtask

   // sends one frame; limit < 0 sends it all and records expected words
   task automatic send_frame(input int f, input int limit);
      int w, n, nb, total, dly;
      w   = 2 << cfg_wsize;
      n   = int'(cfg_nchan);
      dly = int'(cfg_delay);
      nb  = 0;
      for (int ch = 0; ch < n; ch++) begin
         int v;
         v = word_val(f, ch, w);
         if (limit < 0 && cfg_active[ch]) begin
            exp_ch[n_exp] = ch;
            exp_dt[n_exp] = v;
            n_exp++;
         end
         for (int b = 0; b < w; b++) begin
            bits[nb] = cfg_lsb_first ? ((v >> b) & 1) : ((v >> (w - 1 - b)) & 1);
            nb++;
         end
      end
      total = (limit < 0) ? dly + nb : limit;
      bit_period(1'b0, 1'b0);
      for (int k = 0; k < total; k++)
         bit_period(k == 0, (k < dly) ? 1'b1 : bits[k - dly][0]);
   endtask

   task automatic compare_words(input string req);
      check(n_act == n_exp, {req, " word count"}, n_act, n_exp);
      for (int i = 0; i < n_exp && i < n_act; i++) begin
         check(act_ch[i] == exp_ch[i], {req, " channel"}, act_ch[i], exp_ch[i]);
         check(act_dt[i] == exp_dt[i], {req, " data"}, act_dt[i], exp_dt[i]);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check(word_valid == 1'b0, "R1 word_valid", int'(word_valid), 0);
      check(sync_err == 1'b0,   "R1 sync_err",   int'(sync_err), 0);
      check(wr_offset == 8'd0,  "R1 wr_offset",  int'(wr_offset), 0);
      check(irq_a == 1'b0 && irq_b == 1'b0, "R1 irq", int'({irq_a, irq_b}), 0);

      // sweep: word size, edge, polarity, delay, bit order; rotating mask
      for (int combo = 0; combo < 128; combo++) begin
         cfg_wsize     = combo[1:0];
         cfg_edge_fall = combo[2];
         cfg_sync_low  = combo[3];
         cfg_delay     = combo[5:4];
         cfg_lsb_first = combo[6];
         cfg_nchan     = 9'd3;
         cfg_active    = '0;
         cfg_active[2:0] = 3'((combo * 5 + 3) & 7);
         cfg_buf_len   = 8'd0;
         do_reset();
         send_frame(combo, -1);
         repeat (8) @(negedge clk);
         compare_words("R2 R3 R4 R5 R6 R7 sweep");
         check(wr_offset == 8'd1, "R10 sweep offset", int'(wr_offset), 1);
         check(cnt_err == 0, "R9 sweep no error", cnt_err, 0);
         // R8 trailing bits after the last channel yield nothing
         for (int t = 0; t < 3; t++) bit_period(1'b0, t[0]);
         repeat (8) @(negedge clk);
         check(n_act == n_exp, "R8 trailing bits ignored", n_act, n_exp);
      end

      // R8 largest frame: 256 two-bit channels, all enabled
      cfg_wsize = 2'd0; cfg_edge_fall = 1'b0; cfg_sync_low = 1'b0;
      cfg_delay = 2'd2; cfg_lsb_first = 1'b0; cfg_nchan = 9'd256;
      cfg_active = '1;
      do_reset();
      send_frame(7, -1);
      repeat (8) @(negedge clk);
      compare_words("R8 full frame");
      check(n_act > 255 && act_ch[255] == 255, "R8 last channel", n_act > 255 ? act_ch[255] : -1, 255);

      // R8 single channel, 16-bit LSB first, two frames
      cfg_wsize = 2'd3; cfg_lsb_first = 1'b1; cfg_nchan = 9'd1; cfg_delay = 2'd0;
      do_reset();
      send_frame(3, -1);
      send_frame(4, -1);
      repeat (8) @(negedge clk);
      compare_words("R8 R6 single channel");
      check(wr_offset == 8'd2, "R10 two frames", int'(wr_offset), 2);

      // R10 R11 offset wrap and thresholds
      cfg_wsize = 2'd0; cfg_lsb_first = 1'b0; cfg_nchan = 9'd1;
      cfg_buf_len = 8'd5; cfg_thr_a = 8'd2; cfg_thr_b = 8'd0;
      do_reset();
      for (int f = 1; f <= 7; f++) begin
         send_frame(f, -1);
         repeat (8) @(negedge clk);
         check(wr_offset == 8'(f % 5), "R10 offset wrap", int'(wr_offset), f % 5);
      end
      check(cnt_ia == 2, "R11 irq_a pulses", cnt_ia, 2);
      check(cnt_ib == 1, "R11 irq_b pulses on wrap", cnt_ib, 1);

      // R9 early frame start
      cfg_buf_len = 8'd0; cfg_thr_a = 8'd200; cfg_thr_b = 8'd201;
      cfg_wsize = 2'd2; cfg_nchan = 9'd2; cfg_delay = 2'd1; cfg_active = '1;
      cfg_sync_low = 1'b1; cfg_edge_fall = 1'b1;
      do_reset();
      send_frame(20, 5);
      send_frame(21, -1);
      repeat (8) @(negedge clk);
      check(cnt_err == 1, "R9 sync_err pulses", cnt_err, 1);
      compare_words("R9 restarted frame");
      check(wr_offset == 8'd1, "R9 aborted frame not counted", int'(wr_offset), 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule